// File: doc/BRIEF.md
# Streaming Palindrome Checker

This block takes a text string one byte per cycle and decides whether it reads the same in both directions. Letters are folded to lower case before they are stored, and spaces are dropped, so only letters and digits take part in the decision. When the byte flagged as the end of the string arrives, a sequencer walks two pointers toward each other. It compares one pair of stored characters per cycle and stops at the first pair that differs.

The verdict appears in two forms. Ten indicator lines show it as a lit half, and a byte stream with valid/ready handshaking carries one of two fixed ASCII texts. While the comparison runs and the text is sent, the input is closed, so each string gets exactly one verdict and one message.

Top module: `pal_stream_check`

## Requirements
- R1: The letters A-Z (0x41-0x5A) and a-z (0x61-0x7A) compare as equal to their other-case form, so "My gym" is a palindrome.
- R2: Space bytes (0x20) are never stored and never compared, so "step on no pets" is a palindrome.
- R3: A string that has fewer than two characters other than space gets the non-palindrome verdict, whatever those characters are.
- R4: A palindrome verdict sets `led` to 10'h01F, so bits 4..0 are lit and bits 9..5 are dark. `led` keeps its value until the next verdict and is 0 after reset.
- R5: A non-palindrome verdict sets `led` to 10'h3E0, so bits 9..5 are lit and bits 4..0 are dark.
- R6: After a palindrome verdict the output stream carries the 19 bytes "Palindrome detected". After a non-palindrome verdict it carries the 16 bytes "Not a palindrome". Bytes go out first character first, with no terminator.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_data` and `msg_last` hold their values. `msg_last` is high only on the final byte of the text.
- R8: Up to DEPTH (default 64) characters other than space are stored. A string with more than DEPTH such characters gets the non-palindrome verdict.
- R9: A string is accepted when its byte with `in_last` high is taken. The first message byte is then valid c clock edges later. c is 1 for a short or overflowed string. Otherwise c is i+1, where i is the first pointer position at which the pointers have met or crossed, or at which the pair differs.
- R10: `in_ready` is low from the edge that takes a byte with `in_last` high until the edge that transfers the final message byte. It is high again after that edge.
- R11: After reset, `in_ready` is 1, `msg_valid` is 0 and `led` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input character |
| in_last | input | 1 | Marks the final byte of the string |
| in_ready | output | 1 | Block accepts an input byte |
| led | output | 10 | Verdict indicators, bit 9 leftmost |
| msg_valid | output | 1 | Message byte present |
| msg_data | output | 8 | Message character |
| msg_last | output | 1 | Marks the final message byte |
| msg_ready | input | 1 | Sink accepts the message byte |

## Verification
The assertions assume that the input bytes are only letters, digits or space, and that the source follows the handshake, offering bytes only through `in_valid` and `in_ready`. The checker's count of stored characters also relies on no string holding more than 255 characters other than space. The bench sends only legal characters and never sends a string longer than 65 characters. It throttles `msg_ready` with a fixed pattern, so every message sees both stalled and flowing cycles.

// File: rtl/pal_stream_check.sv
module pal_stream_check #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic [9:0] led,
  output logic       msg_valid,
  output logic [7:0] msg_data,
  output logic       msg_last,
  input  logic       msg_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [8*19-1:0] YES_TXT = "Palindrome detected";
  localparam logic [8*16-1:0] NO_TXT  = "Not a palindrome";
  localparam logic [9:0] LED_YES = 10'h01F;
  localparam logic [9:0] LED_NO  = 10'h3E0;

  typedef enum logic [1:0] {S_LOAD, S_CMP, S_MSG} state_t;

  state_t        st;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt, head, tail;
  logic          ovf, pass;
  logic [4:0]    idx;

  wire       take     = in_valid && in_ready;
  wire       is_space = in_data == 8'h20;
  wire       is_upper = in_data >= 8'h41 && in_data <= 8'h5A;
  wire [7:0] folded   = is_upper ? in_data + 8'h20 : in_data;
  wire       full     = cnt == CW'(DEPTH);
  wire       short_s  = ovf || cnt < CW'(2);
  wire       meet     = head >= tail;
  wire       differ   = mem[head[AW-1:0]] != mem[tail[AW-1:0]];

  assign in_ready  = st == S_LOAD;
  assign msg_valid = st == S_MSG;
  assign msg_data  = pass ? YES_TXT[(18 - idx) * 8 +: 8] : NO_TXT[(15 - idx) * 8 +: 8];
  assign msg_last  = msg_valid && (idx == (pass ? 5'd18 : 5'd15));

  always_ff @(posedge clk)
    if (take && !is_space && !full) mem[cnt[AW-1:0]] <= folded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_LOAD;
      cnt  <= '0;
      head <= '0;
      tail <= '0;
      ovf  <= 1'b0;
      pass <= 1'b0;
      idx  <= '0;
      led  <= '0;
    end else begin
      case (st)
        S_LOAD: if (take) begin
          if (!is_space) begin
            if (full) ovf <= 1'b1;
            else      cnt <= cnt + CW'(1);
          end
          if (in_last) begin
            st   <= S_CMP;
            head <= '0;
            tail <= (is_space || full) ? cnt - CW'(1) : cnt;
          end
        end
        S_CMP: begin
          idx <= '0;
          if (short_s || (!meet && differ)) begin
            pass <= 1'b0;
            led  <= LED_NO;
            st   <= S_MSG;
          end else if (meet) begin
            pass <= 1'b1;
            led  <= LED_YES;
            st   <= S_MSG;
          end else begin
            head <= head + CW'(1);
            tail <= tail - CW'(1);
          end
        end
        default: if (msg_ready) begin
          if (msg_last) begin
            st  <= S_LOAD;
            cnt <= '0;
            ovf <= 1'b0;
          end else begin
            idx <= idx + 5'd1;
          end
        end
      endcase
    end
  end
endmodule

module pal_stream_check_sva #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic [9:0] led,
  input logic       msg_valid,
  input logic [7:0] msg_data,
  input logic       msg_last,
  input logic       msg_ready
);
  logic [7:0] sig;

  always_ff @(posedge clk) begin
    if (!rst_n) sig <= '0;
    else if (msg_valid && msg_ready && msg_last) sig <= '0;
    else if (in_valid && in_ready && in_data != 8'h20 && sig != 8'hFF) sig <= sig + 8'd1;
  end

  AST_LED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    led == 10'h000 || led == 10'h01F || led == 10'h3E0); // R4
  AST_LED_ONLY_AT_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> msg_valid && !$past(msg_valid)); // R4
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_last)); // R7
  AST_INPUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !in_ready); // R10
  AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_last |=> in_ready && !msg_valid); // R10
  AST_SHORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && sig < 8'd2 |-> led == 10'h3E0); // R3
  AST_OVERFLOW_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) && sig > 8'(DEPTH) |-> led == 10'h3E0); // R8
endmodule

bind pal_stream_check pal_stream_check_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .led(led), .msg_valid(msg_valid), .msg_data(msg_data),
  .msg_last(msg_last), .msg_ready(msg_ready)
);

// File: tb/pal_stream_check_bench.sv
module pal_stream_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, msg_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, msg_valid, msg_last;
  logic [9:0] led;
  logic [7:0] msg_data;
  int total = 0, bad = 0, rcyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pal_stream_check #(.DEPTH(DEPTH)) u_pal_stream_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .led(led), .msg_valid(msg_valid),
    .msg_data(msg_data), .msg_last(msg_last), .msg_ready(msg_ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input string s, input string tag);
    byte q[$];
    byte c8;
    int n, lat, k, lat_exp;
    bit yes;
    string em;
    for (int i = 0; i < s.len(); i++) begin
      c8 = s[i];
      if (c8 == 8'h20) continue;
      if (c8 >= 8'h41 && c8 <= 8'h5A) c8 = c8 + 8'h20;
      q.push_back(c8);
    end
    n = q.size();
    if (n < 2 || n > DEPTH) begin
      yes = 1'b0;
      lat_exp = 1;
    end else begin
      int i = 0;
      yes = 1'b0;
      forever begin
        if (i >= n - 1 - i) begin yes = 1'b1; break; end
        if (q[i] != q[n - 1 - i]) break;
        i++;
      end
      lat_exp = i + 1;
    end
    em = yes ? "Palindrome detected" : "Not a palindrome";

    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = s[i];
      in_last  = (i == s.len() - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (msg_valid || lat > 200) break;
    end
    chk(lat == lat_exp, "R9 latency", lat, lat_exp);
    chk(led == (yes ? 10'h01F : 10'h3E0), yes ? {tag, " R4"} : {tag, " R5"}, led, yes ? 10'h01F : 10'h3E0);

    k = 0;
    while (k < em.len() && rcyc < 100000) begin
      msg_ready = (rcyc % 3) != 1;
      rcyc++;
      chk(msg_valid && !in_ready, "R10 busy", {in_ready, msg_valid}, 2'b01);
      chk(msg_data == em[k], "R6 byte", msg_data, em[k]);
      chk(msg_last == (k == em.len() - 1), "R7 last", msg_last, k == em.len() - 1);
      @(posedge clk);
      if (msg_ready) k++;
      @(negedge clk);
    end
    msg_ready = 1'b0;
    chk(in_ready && !msg_valid, "R10 reopen", {in_ready, msg_valid}, 2'b10);
    chk(led == (yes ? 10'h01F : 10'h3E0), "R4 led held", led, yes ? 10'h01F : 10'h3E0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string a64, a65;
    a64 = "";
    for (int i = 0; i < DEPTH; i++) a64 = {a64, "a"};
    a65 = {a64, "A"};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !msg_valid && led == 10'h000, "R11 reset", {in_ready, msg_valid, led}, 12'h800);

    run("level", "R1");
    run("8448", "R1");
    run("step on no pets", "R2");
    run("My gym", "R1");
    run("Was it a car or a cat I saw", "R2");
    run("Palindrome", "R5");
    run("First level", "R5");
    run("a", "R3");
    run("  A  ", "R3");
    run(" ", "R3");
    run("Aa", "R1");
    run("ab", "R5");
    run("abcXba", "R9");
    run(a64, "R8");
    run(a65, "R8");
    run("Zz9 9zZ", "R2");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule